// File: doc/BRIEF.md
# I2C Serial Memory Slave Engine

This block is the bus-facing controller of a small serial memory that answers on a two-wire I2C bus. It takes the raw SCL and SDA lines, brings them into a faster system clock domain, and recognises start and stop conditions. It moves bytes in and out most significant bit first and drives an open-drain SDA pull-down enable. When the device identifier and the strap pins match, it runs byte writes, page writes, current-address reads, random reads and sequential reads against an internal word pointer.

Toward the storage side it issues one write request per accepted data byte and a commit request when the transaction ends. It presents the pointer as a read address and expects the addressed byte back one clock later. A busy flag comes back from the storage side while an internal write cycle runs. While that flag is high, the engine stays silent. When the write-protect input is high, data bytes are refused. The low slave-address bits that are not compared with straps act as block-select bits and become the upper bits of the memory address.

Top module: `i2c_mem_slave`

## Requirements
- R1: After a synchronous reset, sda_oe, wr_req and commit_req are 0 and rd_addr is 0.
- R2: The engine reacts only after a start condition (SDA falling while SCL is high). Bytes clocked without a preceding start are never acknowledged. A stop condition (SDA rising while SCL is high) ends the transaction.
- R3: A slave-address byte is acknowledged only if bits 7..4 equal 1010 and each bit 3..1 that is not a block-select bit equals its strap pin: bit 3 against strap_addr[2], bit 2 against strap_addr[1], bit 1 against strap_addr[0]. The lowest BLK_BITS of bits 3..1, counted from bit 1, are block-select bits. Bit 0 is 1 for read and 0 for write.
- R4: Bytes travel MSB first. The engine acknowledges by pulling SDA low during the ninth clock. sda_oe changes only while the synchronised SCL is low, HOLD_CLKS clocks after its falling edge.
- R5: In a write, the byte after the slave address loads the pointer as {block-select bits, byte}. Each data byte is acknowledged and produces a one-cycle wr_req carrying the pointer and the byte. The pointer then advances in its low PAGE_BITS bits only, so it wraps within a 2^PAGE_BITS-byte page.
- R6: commit_req pulses for one cycle after a stop only if at least one data byte was accepted since the last start. A transaction that only sets the pointer commits nothing.
- R7: While wp_in is 1, the slave address and word address are still acknowledged. Data bytes get no acknowledge, no wr_req is issued, and the following stop gives no commit_req.
- R8: While busy_in is 1, a slave address that would otherwise match is not acknowledged. Once busy_in is 0, the same address is acknowledged.
- R9: A read returns the byte at the pointer and then advances the pointer by one. After a write, a current-address read returns the address after the last one written.
- R10: In a sequential read, each master acknowledge yields the next byte, and the pointer wraps from the top address to 0. After a master not-acknowledge, SDA is released until the next start or stop.
- R11: A repeated start after the word address, followed by a read address, reads from the newly loaded pointer.
- R12: A start or stop in the middle of a byte aborts that byte. A later correctly framed transaction is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line (as seen on the wire) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_addr | input | 3 | Device address strap pins |
| wp_in | input | 1 | Write protect, 1 refuses data bytes |
| wr_req | output | 1 | One-cycle request to store a byte |
| wr_addr | output | 8+BLK_BITS | Address of the byte to store |
| wr_data | output | 8 | Byte to store |
| commit_req | output | 1 | One-cycle request to start the internal write cycle |
| busy_in | input | 1 | Internal write cycle in progress |
| rd_addr | output | 8+BLK_BITS | Current pointer, used as read address |
| rd_data | input | 8 | Byte at rd_addr, one clock after the address |

## Verification
A bad pointer shows up at the first byte read after it goes wrong. The byte on SDA no longer matches the bench's own image of memory, and a bad page wrap gives a wrong wr_addr on the first write request past the page end. A bad bit count or state shows up within the same byte as a missing or misplaced acknowledge: the master samples SDA high where a low was due, or the reverse. An SDA enable that moves while SCL is high would form a false start or stop right away, so a checker flags it on the same clock. Commit and write-protect errors appear as a missing or extra commit_req pulse one clock after the stop.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADR,
    ST_WDAT,
    ST_RDAT,
    ST_HOLD
  } eng_state_t;

  localparam logic [3:0] DEV_ID = 4'b1010;
endpackage

// File: rtl/i2c_sync.sv
module i2c_sync #(
  parameter int STAGES = 2,
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= RST_VAL;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= RST_VAL;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond #(
  parameter int HOLD_CLKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic drv_stb
);
  localparam int CW = $clog2(HOLD_CLKS + 1);

  logic          scl_q, sda_q;
  logic [CW-1:0] cnt;

  always_comb begin
    scl_rise  = scl_s & ~scl_q;
    scl_fall  = ~scl_s & scl_q;
    start_det = scl_s & scl_q & sda_q & ~sda_s;
    stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    drv_stb   = (cnt == CW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      cnt   <= '0;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
      if (scl_fall)        cnt <= CW'(HOLD_CLKS);
      else if (cnt != '0)  cnt <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match import i2c_mem_pkg::*; #(
  parameter int BLK_BITS = 1
) (
  input  logic [7:1] dev_hi,
  input  logic [2:0] strap,
  output logic       hit,
  output logic [2:0] blk
);
  logic [2:0] pin_ok;

  generate
    for (genvar i = 0; i < 3; i++) begin : g_bit
      if (i < BLK_BITS) begin : g_blk
        assign blk[i]    = dev_hi[1+i];
        assign pin_ok[i] = 1'b1;
      end else begin : g_pin
        assign blk[i]    = 1'b0;
        assign pin_ok[i] = (dev_hi[1+i] == strap[i]);
      end
    end
  endgenerate

  assign hit = (dev_hi[7:4] == DEV_ID) && (&pin_ok);
endmodule

// File: rtl/i2c_mem_ctrl.sv
module i2c_mem_ctrl import i2c_mem_pkg::*; #(
  parameter int AW = 9,
  parameter int PAGE_BITS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          drv_stb,
  input  logic          sda_s,
  input  logic          wp,
  input  logic          busy,
  input  logic          dev_hit,
  input  logic [2:0]    dev_blk,
  input  logic [7:0]    rd_data,
  output logic [7:0]    sh_q,
  output logic          sda_oe,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          commit_req,
  output logic [AW-1:0] ptr_q
);
  localparam logic [PAGE_BITS-1:0] PG_ONE  = PAGE_BITS'(1);
  localparam logic [AW-1:0]        PTR_ONE = AW'(1);

  eng_state_t st;
  logic [3:0] bcnt;
  logic       ack_ph, m_ack, oe_pend, wrote;
  logic [7:0] tx;
  logic [2:0] blk_q;
  logic       active;

  assign active = (st == ST_DEV) || (st == ST_WADR) || (st == ST_WDAT) || (st == ST_RDAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      bcnt       <= '0;
      ack_ph     <= 1'b0;
      m_ack      <= 1'b0;
      oe_pend    <= 1'b0;
      wrote      <= 1'b0;
      sh_q       <= '0;
      tx         <= '0;
      blk_q      <= '0;
      ptr_q      <= '0;
      sda_oe     <= 1'b0;
      wr_req     <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      commit_req <= 1'b0;
    end else begin
      wr_req     <= 1'b0;
      commit_req <= 1'b0;
      if (start_det) begin
        st      <= ST_DEV;
        bcnt    <= '0;
        ack_ph  <= 1'b0;
        oe_pend <= 1'b0;
        sda_oe  <= 1'b0;
        wrote   <= 1'b0;
      end else if (stop_det) begin
        st         <= ST_IDLE;
        bcnt       <= '0;
        ack_ph     <= 1'b0;
        oe_pend    <= 1'b0;
        sda_oe     <= 1'b0;
        commit_req <= wrote;
        wrote      <= 1'b0;
      end else begin
        if (drv_stb) sda_oe <= oe_pend;
        if (active && scl_rise) begin
          if (ack_ph) begin
            if (st == ST_RDAT) m_ack <= ~sda_s;
          end else begin
            sh_q <= {sh_q[6:0], sda_s};
            tx   <= {tx[6:0], 1'b0};
            bcnt <= bcnt + 4'd1;
          end
        end else if (active && scl_fall) begin
          if (ack_ph) begin
            ack_ph <= 1'b0;
            bcnt   <= '0;
            if (st == ST_RDAT && m_ack) begin
              tx      <= rd_data;
              oe_pend <= ~rd_data[7];
            end else begin
              oe_pend <= 1'b0;
              if (st == ST_RDAT) st <= ST_HOLD;
            end
          end else if (bcnt == 4'd8) begin
            ack_ph <= 1'b1;
            case (st)
              ST_DEV: begin
                if (dev_hit && !busy) begin
                  oe_pend <= 1'b1;
                  blk_q   <= dev_blk;
                  if (sh_q[0]) begin
                    st    <= ST_RDAT;
                    m_ack <= 1'b1;
                  end else begin
                    st    <= ST_WADR;
                  end
                end else begin
                  oe_pend <= 1'b0;
                  st      <= ST_IDLE;
                end
              end
              ST_WADR: begin
                ptr_q   <= AW'({blk_q, sh_q});
                oe_pend <= 1'b1;
                st      <= ST_WDAT;
              end
              ST_WDAT: begin
                if (wp) begin
                  oe_pend <= 1'b0;
                  st      <= ST_HOLD;
                end else begin
                  oe_pend <= 1'b1;
                  wr_req  <= 1'b1;
                  wr_addr <= ptr_q;
                  wr_data <= sh_q;
                  wrote   <= 1'b1;
                  ptr_q   <= {ptr_q[AW-1:PAGE_BITS], ptr_q[PAGE_BITS-1:0] + PG_ONE};
                end
              end
              default: begin
                oe_pend <= 1'b0;
                ptr_q   <= ptr_q + PTR_ONE;
              end
            endcase
          end else if (st == ST_RDAT) begin
            oe_pend <= ~tx[7];
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave import i2c_mem_pkg::*; #(
  parameter int BLK_BITS = 1,
  parameter int PAGE_BITS = 4,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CLKS = 4,
  localparam int AW = 8 + BLK_BITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_oe,
  input  logic [2:0]    strap_addr,
  input  logic          wp_in,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          commit_req,
  input  logic          busy_in,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data
);
  logic [1:0] syn;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_det, stop_det, drv_stb;
  logic [7:0] sh_q;
  logic       dev_hit;
  logic [2:0] dev_blk;

  i2c_sync #(.STAGES(SYNC_STAGES), .W(2), .RST_VAL(2'b11)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_in, sda_in}),
    .q   (syn)
  );

  assign scl_s = syn[1];
  assign sda_s = syn[0];

  i2c_bus_cond #(.HOLD_CLKS(HOLD_CLKS)) u_cond (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .drv_stb   (drv_stb)
  );

  i2c_addr_match #(.BLK_BITS(BLK_BITS)) u_match (
    .dev_hi (sh_q[7:1]),
    .strap  (strap_addr),
    .hit    (dev_hit),
    .blk    (dev_blk)
  );

  i2c_mem_ctrl #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .drv_stb    (drv_stb),
    .sda_s      (sda_s),
    .wp         (wp_in),
    .busy       (busy_in),
    .dev_hit    (dev_hit),
    .dev_blk    (dev_blk),
    .rd_data    (rd_data),
    .sh_q       (sh_q),
    .sda_oe     (sda_oe),
    .wr_req     (wr_req),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .commit_req (commit_req),
    .ptr_q      (rd_addr)
  );
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk #(
  parameter int AW = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_s,
  input logic          start_det,
  input logic          stop_det,
  input logic          scl_fall,
  input logic          sda_oe,
  input logic          wr_req,
  input logic          commit_req,
  input logic          wp_in,
  input logic          busy_in,
  input logic [AW-1:0] rd_addr
);
  assert_oe_rise_scl_low_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s) else $error("sda_oe asserted while SCL high");

  assert_oe_fall_scl_low_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_oe) |-> (!scl_s || $past(start_det) || $past(stop_det)))
    else $error("sda_oe released while SCL high");

  assert_wr_single_R5: assert property (@(posedge clk) disable iff (rst)
    wr_req |=> !wr_req) else $error("wr_req longer than one cycle");

  assert_commit_after_stop_R6: assert property (@(posedge clk) disable iff (rst)
    commit_req |-> $past(stop_det)) else $error("commit without stop");

  assert_commit_not_with_write_R6: assert property (@(posedge clk) disable iff (rst)
    !(wr_req && commit_req)) else $error("commit and write together");

  assert_no_write_protected_R7: assert property (@(posedge clk) disable iff (rst)
    wr_req |-> !$past(wp_in)) else $error("write while protected");

  assert_quiet_while_busy_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !busy_in) else $error("SDA driven while busy");

  assert_ptr_moves_on_fall_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_addr) |-> $past(scl_fall)) else $error("pointer moved off SCL fall");
endmodule

bind i2c_mem_slave i2c_mem_slave_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .scl_s      (scl_s),
  .start_det  (start_det),
  .stop_det   (stop_det),
  .scl_fall   (scl_fall),
  .sda_oe     (sda_oe),
  .wr_req     (wr_req),
  .commit_req (commit_req),
  .wp_in      (wp_in),
  .busy_in    (busy_in),
  .rd_addr    (rd_addr)
);

// File: tb/tb_i2c_mem_slave.sv
module tb_i2c_mem_slave;
  localparam int BLK_BITS  = 1;
  localparam int AW        = 8 + BLK_BITS;
  localparam int DEPTH     = 1 << AW;
  localparam int Q         = 40;
  localparam int BUSY_CLKS = 3000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          m_scl = 1'b1, m_sda = 1'b1;
  logic          wp = 1'b0;
  logic [2:0]    strap = 3'b101;
  logic          busy;
  logic [7:0]    rd_q;
  logic          sda_oe, wr_req, commit_req;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0]    wr_data;
  wire           sda_line = m_sda & ~sda_oe;

  i2c_mem_slave #(.BLK_BITS(BLK_BITS)) dut (
    .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_line), .sda_oe(sda_oe),
    .strap_addr(strap), .wp_in(wp), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit_req(commit_req), .busy_in(busy),
    .rd_addr(rd_addr), .rd_data(rd_q)
  );

  logic [7:0]    mem [DEPTH];
  logic [7:0]    exp_mem [DEPTH];
  logic [AW-1:0] wlog_addr [64];
  logic [7:0]    wlog_data [64];
  int            wr_cnt = 0, commit_cnt = 0, busy_cnt = 0;
  int            n_checks = 0, n_fail = 0;

  assign busy = (busy_cnt != 0);

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) ^ (i >> 3));
  endfunction

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i]     = pat(i);
      exp_mem[i] = pat(i);
    end
  end

  always @(posedge clk) begin
    rd_q <= mem[rd_addr];
    if (wr_req) begin
      mem[wr_addr] <= wr_data;
      wlog_addr[wr_cnt % 64] = wr_addr;
      wlog_data[wr_cnt % 64] = wr_data;
      wr_cnt = wr_cnt + 1;
    end
    if (commit_req) begin
      commit_cnt = commit_cnt + 1;
      busy_cnt  <= BUSY_CLKS;
    end else if (busy_cnt != 0) begin
      busy_cnt  <= busy_cnt - 1;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dev(logic blk, logic rnw);
    return {4'b1010, strap[2], strap[1], blk, rnw};
  endfunction

  task automatic m_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic m_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic bit_out(logic b);
    m_sda = b;    tick(Q);
    m_scl = 1'b1; tick(Q);
    m_scl = 1'b0; tick(2);
  endtask

  task automatic bit_in(output logic b);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q / 2);
    b = sda_line; tick(Q / 2);
    m_scl = 1'b0; tick(2);
  endtask

  task automatic m_send(logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(b);
    ack = ~b;
  endtask

  task automatic m_recv(output logic [7:0] v, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      v[i] = b;
    end
    bit_out(~ack);
  endtask

  task automatic wait_idle();
    while (busy) tick(1);
    tick(4);
  endtask

  task automatic t_reset();
    check("R1 sda_oe", int'(sda_oe), 0);
    check("R1 wr_req", int'(wr_req), 0);
    check("R1 commit_req", int'(commit_req), 0);
    check("R1 rd_addr", int'(rd_addr), 0);
  endtask

  task automatic t_no_start();
    logic a;
    m_scl = 1'b0; tick(Q);
    m_send(dev(1'b0, 1'b0), a);
    check("R2 no ack without start", int'(a), 0);
    m_scl = 1'b1; tick(Q);
  endtask

  task automatic t_bad_addr();
    logic a;
    m_start();
    m_send({4'b1011, strap[2], strap[1], 2'b00}, a);
    check("R3 wrong identifier", int'(a), 0);
    m_stop();
    m_start();
    m_send({4'b1010, ~strap[2], strap[1], 2'b00}, a);
    check("R3 wrong strap", int'(a), 0);
    m_stop();
  endtask

  task automatic t_byte_write();
    logic a;
    int w0 = wr_cnt, c0 = commit_cnt;
    m_start();
    m_send(dev(1'b1, 1'b0), a); check("R3 address ack", int'(a), 1);
    m_send(8'h10, a);           check("R5 word ack", int'(a), 1);
    m_send(8'h5A, a);           check("R4 data ack", int'(a), 1);
    m_stop();
    tick(4);
    exp_mem[9'h110] = 8'h5A;
    check("R5 one write", wr_cnt - w0, 1);
    check("R5 write addr", int'(wlog_addr[w0 % 64]), 'h110);
    check("R5 write data", int'(wlog_data[w0 % 64]), 'h5A);
    check("R6 commit after data", commit_cnt - c0, 1);
  endtask

  task automatic t_busy_poll();
    logic a;
    int c0;
    m_start();
    m_send(dev(1'b0, 1'b0), a);
    check("R8 no ack while busy", int'(a), 0);
    m_stop();
    for (int k = 0; k < 12; k++) begin
      m_start();
      m_send(dev(1'b0, 1'b0), a);
      if (a) break;
      m_stop();
    end
    check("R8 poll acked after busy", int'(a), 1);
    check("R8 busy low at ack", int'(busy), 0);
    c0 = commit_cnt;
    m_stop();
    tick(4);
    check("R6 no commit without data", commit_cnt - c0, 0);
  endtask

  task automatic t_page_write();
    logic a;
    int w0 = wr_cnt;
    logic [7:0] d [4] = '{8'hA1, 8'hA2, 8'hA3, 8'hA4};
    logic [AW-1:0] ea [4] = '{9'h01E, 9'h01F, 9'h010, 9'h011};
    m_start();
    m_send(dev(1'b0, 1'b0), a);
    m_send(8'h1E, a);
    for (int i = 0; i < 4; i++) begin
      m_send(d[i], a);
      check("R5 page data ack", int'(a), 1);
      exp_mem[ea[i]] = d[i];
    end
    m_stop();
    tick(4);
    for (int i = 0; i < 4; i++)
      check("R5 page wrap addr", int'(wlog_addr[(w0 + i) % 64]), int'(ea[i]));
    wait_idle();
  endtask

  task automatic t_current_read();
    logic a;
    logic [7:0] v;
    for (int i = 0; i < 2; i++) begin
      m_start();
      m_send(dev(1'b0, 1'b1), a);
      check("R9 read address ack", int'(a), 1);
      m_recv(v, 1'b0);
      m_stop();
      check("R9 R13 current read byte", int'(v), int'(exp_mem[9'h012 + i]));
    end
  endtask

  task automatic t_wp();
    logic a;
    int w0 = wr_cnt, c0 = commit_cnt;
    wp = 1'b1;
    m_start();
    m_send(dev(1'b0, 1'b0), a); check("R7 address ack when protected", int'(a), 1);
    m_send(8'h40, a);           check("R7 word ack when protected", int'(a), 1);
    m_send(8'h77, a);           check("R7 data refused", int'(a), 0);
    m_stop();
    tick(4);
    check("R7 no wr_req", wr_cnt - w0, 0);
    check("R7 no commit", commit_cnt - c0, 0);
    wp = 1'b0;
  endtask

  task automatic t_random_read();
    logic a, b;
    logic [7:0] v;
    m_start();
    m_send(dev(1'b1, 1'b0), a);
    m_send(8'h80, a);
    m_start();
    m_send(dev(1'b1, 1'b1), a);
    check("R11 read after repeated start ack", int'(a), 1);
    m_recv(v, 1'b1);
    check("R11 random byte", int'(v), int'(exp_mem[9'h180]));
    m_recv(v, 1'b0);
    check("R10 next byte", int'(v), int'(exp_mem[9'h181]));
    bit_in(b);
    check("R10 released after nack", int'(b), 1);
    m_stop();
  endtask

  task automatic t_seq_wrap();
    logic a;
    logic [7:0] v;
    logic [AW-1:0] ea [4] = '{9'h1FE, 9'h1FF, 9'h000, 9'h001};
    m_start();
    m_send(dev(1'b1, 1'b0), a);
    m_send(8'hFE, a);
    m_start();
    m_send(dev(1'b0, 1'b1), a);
    for (int i = 0; i < 4; i++) begin
      m_recv(v, i < 3);
      check("R10 sequential wrap byte", int'(v), int'(exp_mem[ea[i]]));
    end
    m_stop();
  endtask

  task automatic t_abort();
    logic a;
    logic [7:0] v;
    int w0;
    m_start();
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    m_stop();
    w0 = wr_cnt;
    m_start();
    m_send(dev(1'b0, 1'b0), a); check("R12 ack after mid-byte stop", int'(a), 1);
    m_send(8'h33, a);
    m_send(8'hC3, a);
    m_stop();
    tick(4);
    exp_mem[9'h033] = 8'hC3;
    check("R12 write after abort addr", int'(wlog_addr[w0 % 64]), 'h033);
    wait_idle();
    m_start();
    for (int i = 0; i < 3; i++) bit_out(1'b0);
    m_start();
    m_send(dev(1'b0, 1'b1), a); check("R12 ack after mid-byte start", int'(a), 1);
    m_recv(v, 1'b0);
    m_stop();
    check("R12 R9 read after abort", int'(v), int'(exp_mem[9'h034]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    tick(10);
    rst = 1'b0;
    tick(2);
    t_reset();
    t_no_start();
    t_bad_addr();
    t_byte_write();
    t_busy_poll();
    t_page_write();
    t_current_read();
    t_wp();
    t_random_read();
    t_seq_wrap();
    t_abort();
    tick(20);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule